// File: doc/BRIEF.md
# Configurable Single-Port Synchronous RAM

This block is one synchronous storage array behind a single address bus and a single clock. One cycle can write a word, read a word, or do both at the same address. Parameters fix the array shape, whether a read-enable pin gates the output, what the output shows when a read and a write meet in the same cycle, and whether a second register stage follows the read stage. The timing of every configuration is modelled cycle by cycle, so logic that uses the block can be checked against exact output latencies and hold behaviour.

The read stage is always clocked. Read data appears after the edge that samples the address, or one edge later when the output register is enabled. When the read-enable pin is in use and held low, the output keeps the word from the last enabled read, even while writes go on. A synchronous clear zeroes the last output stage. The storage array itself is never reset.

Top module: `sp_ram_cfg`

## Requirements
- R1: The address port is `$clog2(DEPTH)` bits wide. Every address from 0 to DEPTH-1 holds its own word. A DEPTH/WIDTH pair outside the legal shape list is rejected at elaboration. The legal shapes are 64x8, 64x9, 64x10, 32x16, 32x18, 32x20, 8192x1, 4096x2, 2048x4, 1024x8, 1024x9, 512x16, 512x18, 256x32, 256x36, 16384x8, 16384x9, 8192x16, 8192x18, 4096x32, 4096x36, 2048x64 and 2048x72.
- R2: While `rst_n` is low, `q` is all zeros. It stays all zeros after release until a read or clear loads it.
- R3: With the read active (`rden`=1 when `USE_RDEN`=1) and `wren`=0, `q` shows the word stored at `addr` after the next rising edge when `OUT_REG`=0.
- R4: With `USE_RDEN`=1 and `rden`=0, the read stage keeps the value from the most recent enabled read, whether or not a write happens in that cycle.
- R5: With `RDW_MODE`=RDW_NEW, an active read together with a write loads the read stage with `wdata`.
- R6: With `RDW_MODE`=RDW_OLD, an active read together with a write loads the read stage with the word held at `addr` before the write.
- R7: With `RDW_MODE`=RDW_DC, the read stage value after an active read together with a write is undefined (X in simulation). The write still stores `wdata`, and a later read returns it.
- R8: With `USE_RDEN`=0, `rden` is ignored and every cycle is a read.
- R9: With `OUT_REG`=1, `q` equals the read-stage value of the previous cycle, so read data comes one edge later than with `OUT_REG`=0.
- R10: `clr`=1 at a rising edge makes `q` all zeros after that edge. It takes priority over a read and leaves the stored words unchanged.
- R11: With `wren`=1, `wdata` is stored at `addr` on the rising edge, whatever the level of `rden`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every action happens on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the output stages |
| clr | input | 1 | Synchronous clear of the last output stage |
| addr | input | ADDR_W | Shared read/write word address |
| wdata | input | WIDTH | Word to store |
| wren | input | 1 | Write strobe |
| rden | input | 1 | Read enable, used only when USE_RDEN=1 |
| q | output | WIDTH | Read data |

## Verification
The checker watches four things on every cycle: the hold of the read stage while the read enable is low, the new-data result of a same-cycle read and write, the one-cycle copy from the read stage into the output register, and the zero output after a clear or during reset. Stored contents cannot be seen from the ports in the same cycle. So old-data results, the ignored read enable, clear leaving the array intact, and the reach of the full address range are shown only by the bench. The bench drives three differently configured instances against a reference memory.

// File: rtl/sp_ram_pkg.sv
package sp_ram_pkg;

  typedef enum logic [1:0] {
    RDW_NEW = 2'd0,
    RDW_OLD = 2'd1,
    RDW_DC  = 2'd2
  } rdw_mode_e;

  // Accepted array shapes, grouped by capacity class.
  function automatic bit shape_legal(input int unsigned depth, input int unsigned width);
    bit ok;
    ok = 1'b0;
    // small shapes
    if (depth == 64 && (width == 8 || width == 9 || width == 10)) ok = 1'b1;
    if (depth == 32 && (width == 16 || width == 18 || width == 20)) ok = 1'b1;
    // mid shapes
    if (depth == 8192 && width == 1) ok = 1'b1;
    if (depth == 4096 && width == 2) ok = 1'b1;
    if (depth == 2048 && width == 4) ok = 1'b1;
    if (depth == 1024 && (width == 8 || width == 9)) ok = 1'b1;
    if (depth == 512 && (width == 16 || width == 18)) ok = 1'b1;
    if (depth == 256 && (width == 32 || width == 36)) ok = 1'b1;
    // large shapes
    if (depth == 16384 && (width == 8 || width == 9)) ok = 1'b1;
    if (depth == 8192 && (width == 16 || width == 18)) ok = 1'b1;
    if (depth == 4096 && (width == 32 || width == 36)) ok = 1'b1;
    if (depth == 2048 && (width == 64 || width == 72)) ok = 1'b1;
    return ok;
  endfunction

endpackage

// File: rtl/sp_ram_array.sv
// Storage array: clocked write, combinational view of the addressed word.
module sp_ram_array #(
  parameter int DEPTH  = 256,
  parameter int WIDTH  = 32,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WIDTH-1:0]  wdata,
  input  logic              wren,
  output logic [WIDTH-1:0]  cur_word
);

  logic [WIDTH-1:0] store [DEPTH];

  // array is deliberately not reset
  always_ff @(posedge clk) begin
    if (wren) begin
      store[addr] <= wdata;
    end
  end

  assign cur_word = store[addr];

endmodule

// File: rtl/sp_ram_rdstage.sv
// Read stage: picks the loaded word per read-during-write mode, holds otherwise.
module sp_ram_rdstage
  import sp_ram_pkg::*;
#(
  parameter int        WIDTH    = 32,
  parameter rdw_mode_e RDW_MODE = RDW_NEW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_here,
  input  logic             rd_act,
  input  logic             wren,
  input  logic [WIDTH-1:0] wdata,
  input  logic [WIDTH-1:0] cur_word,
  output logic [WIDTH-1:0] rd_q
);

  logic [WIDTH-1:0] rdw_word;
  logic [WIDTH-1:0] rd_nxt;
  logic             rd_en;

  generate
    if (RDW_MODE == RDW_NEW) begin : g_new
      assign rdw_word = wdata;
    end else if (RDW_MODE == RDW_OLD) begin : g_old
      assign rdw_word = cur_word;
    end else begin : g_dc
      assign rdw_word = {WIDTH{1'bx}};
    end
  endgenerate

  // next state
  always_comb begin
    rd_en  = clr_here | rd_act;
    rd_nxt = rd_q;
    if (clr_here) begin
      rd_nxt = '0;
    end else if (rd_act) begin
      rd_nxt = wren ? rdw_word : cur_word;
    end
  end

  // register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
    end else if (rd_en) begin
      rd_q <= rd_nxt;
    end
  end

endmodule

// File: rtl/sp_ram_outreg.sv
// Optional output register with synchronous clear.
module sp_ram_outreg #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] q_nxt;

  always_comb begin
    q_nxt = clr ? '0 : d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else begin
      q <= q_nxt;
    end
  end

endmodule

// File: rtl/sp_ram_cfg.sv
module sp_ram_cfg
  import sp_ram_pkg::*;
#(
  parameter int        DEPTH    = 256,
  parameter int        WIDTH    = 32,
  parameter rdw_mode_e RDW_MODE = RDW_NEW,
  parameter bit        USE_RDEN = 1'b1,
  parameter bit        OUT_REG  = 1'b0,
  localparam int       ADDR_W   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WIDTH-1:0]  wdata,
  input  logic              wren,
  input  logic              rden,
  output logic [WIDTH-1:0]  q
);

  generate
    if (!shape_legal(DEPTH, WIDTH)) begin : g_bad_shape
      $error("sp_ram_cfg: DEPTH/WIDTH pair is not a legal shape");
    end
  endgenerate

  logic [WIDTH-1:0] cur_word;
  logic [WIDTH-1:0] rd_q;
  logic             rd_act;
  logic             clr_rd;

  assign rd_act = USE_RDEN ? rden : 1'b1;
  // clear acts on whichever stage drives q
  assign clr_rd = OUT_REG ? 1'b0 : clr;

  sp_ram_array #(
    .DEPTH (DEPTH),
    .WIDTH (WIDTH),
    .ADDR_W(ADDR_W)
  ) u_array (
    .clk     (clk),
    .addr    (addr),
    .wdata   (wdata),
    .wren    (wren),
    .cur_word(cur_word)
  );

  sp_ram_rdstage #(
    .WIDTH   (WIDTH),
    .RDW_MODE(RDW_MODE)
  ) u_rd (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_here(clr_rd),
    .rd_act  (rd_act),
    .wren    (wren),
    .wdata   (wdata),
    .cur_word(cur_word),
    .rd_q    (rd_q)
  );

  generate
    if (OUT_REG) begin : g_oreg
      sp_ram_outreg #(.WIDTH(WIDTH)) u_oreg (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (clr),
        .d    (rd_q),
        .q    (q)
      );
    end else begin : g_direct
      assign q = rd_q;
    end
  endgenerate

endmodule

// File: rtl/sp_ram_cfg_chk.sv
module sp_ram_cfg_chk
  import sp_ram_pkg::*;
#(
  parameter int        WIDTH    = 32,
  parameter int        ADDR_W   = 8,
  parameter rdw_mode_e RDW_MODE = RDW_NEW,
  parameter bit        USE_RDEN = 1'b1,
  parameter bit        OUT_REG  = 1'b0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clr,
  input logic [ADDR_W-1:0] addr,
  input logic [WIDTH-1:0]  wdata,
  input logic              wren,
  input logic              rden,
  input logic [WIDTH-1:0]  rd_q,
  input logic [WIDTH-1:0]  q
);

  logic rd_on;
  logic rd_clr;
  assign rd_on  = USE_RDEN ? rden : 1'b1;
  assign rd_clr = clr && !OUT_REG;

  // R2: output is zero while reset is held
  always @(negedge clk) begin
    if (!rst_n) begin
      a_r2_reset_zero: assert (q == '0) else $error("R2 q not zero in reset");
    end
  end

  // R4: read stage holds while read enable is low
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (USE_RDEN && !rden && !rd_clr) |=> $stable(rd_q));

  // R5: new-data result on a same-cycle read and write
  a_r5_new_data: assert property (@(posedge clk) disable iff (!rst_n)
    ((RDW_MODE == RDW_NEW) && rd_on && wren && !rd_clr) |=> (rd_q == $past(wdata)));

  // R9: output register trails the read stage by one cycle
  a_r9_pipe: assert property (@(posedge clk) disable iff (!rst_n)
    (OUT_REG && !clr) |=> (q == $past(rd_q)));

  // R10: clear zeroes the output
  a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (q == '0));

endmodule

bind sp_ram_cfg sp_ram_cfg_chk #(
  .WIDTH   (WIDTH),
  .ADDR_W  (ADDR_W),
  .RDW_MODE(RDW_MODE),
  .USE_RDEN(USE_RDEN),
  .OUT_REG (OUT_REG)
) u_chk (
  .clk  (clk),
  .rst_n(rst_n),
  .clr  (clr),
  .addr (addr),
  .wdata(wdata),
  .wren (wren),
  .rden (rden),
  .rd_q (rd_q),
  .q    (q)
);

// File: tb/test_sp_ram_cfg.sv
module test_sp_ram_cfg;
  import sp_ram_pkg::*;

  localparam int DEPTH = 256;
  localparam int WIDTH = 32;
  localparam int AW    = $clog2(DEPTH);

  logic             clk;
  logic             rst_n;
  logic             clr;
  logic [AW-1:0]    addr;
  logic [WIDTH-1:0] wdata;
  logic             wren;
  logic             rden;
  logic [WIDTH-1:0] q_a, q_b, q_c;

  int checks = 0;
  int errors = 0;

  // A: new data, read enable used, unregistered
  sp_ram_cfg #(.DEPTH(DEPTH), .WIDTH(WIDTH), .RDW_MODE(RDW_NEW), .USE_RDEN(1'b1), .OUT_REG(1'b0))
    i_sp_ram_cfg (.clk(clk), .rst_n(rst_n), .clr(clr), .addr(addr), .wdata(wdata),
                  .wren(wren), .rden(rden), .q(q_a));
  // B: old data, read enable used, registered
  sp_ram_cfg #(.DEPTH(DEPTH), .WIDTH(WIDTH), .RDW_MODE(RDW_OLD), .USE_RDEN(1'b1), .OUT_REG(1'b1))
    i_sp_ram_cfg_b (.clk(clk), .rst_n(rst_n), .clr(clr), .addr(addr), .wdata(wdata),
                    .wren(wren), .rden(rden), .q(q_b));
  // C: don't-care, read enable ignored, unregistered
  sp_ram_cfg #(.DEPTH(DEPTH), .WIDTH(WIDTH), .RDW_MODE(RDW_DC), .USE_RDEN(1'b0), .OUT_REG(1'b0))
    i_sp_ram_cfg_c (.clk(clk), .rst_n(rst_n), .clr(clr), .addr(addr), .wdata(wdata),
                    .wren(wren), .rden(rden), .q(q_c));

  initial clk = 1'b0;
  always #5 clk = ~clk;

  typedef struct {
    logic [WIDTH-1:0] ea;
    logic [WIDTH-1:0] eb;
    logic [WIDTH-1:0] ec;
    bit               c_undef;
    string            tag;
  } exp_t;

  exp_t exp_q[$];

  // reference model state
  logic [WIDTH-1:0] mem_m [DEPTH];
  logic [WIDTH-1:0] sa, sb1, rb, sc;
  bit               c_undef;

  task automatic check(input string tag, input logic [WIDTH-1:0] act, input logic [WIDTH-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: apply one cycle and push the expectation for after its edge
  task automatic cyc(input logic [AW-1:0] a, input logic [WIDTH-1:0] d,
                     input logic we, input logic re, input logic cl, input string tag);
    logic [WIDTH-1:0] old;
    logic [WIDTH-1:0] nb2;
    exp_t it;
    @(negedge clk);
    #1;
    addr = a; wdata = d; wren = we; rden = re; clr = cl;
    old = mem_m[a];
    if (cl) sa = '0;
    else if (re) sa = we ? d : old;
    nb2 = cl ? '0 : sb1;
    if (re) sb1 = old;
    rb = nb2;
    if (cl) begin
      sc = '0; c_undef = 1'b0;
    end else if (we) begin
      c_undef = 1'b1;
    end else begin
      sc = old; c_undef = 1'b0;
    end
    if (we) mem_m[a] = d;
    it.ea = sa; it.eb = rb; it.ec = sc; it.c_undef = c_undef; it.tag = tag;
    exp_q.push_back(it);
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      if (exp_q.size() > 0) begin
        exp_t it;
        it = exp_q.pop_front();
        check({it.tag, " A"}, q_a, it.ea);
        check({it.tag, " B"}, q_b, it.eb);
        if (!it.c_undef) check({it.tag, " C"}, q_c, it.ec);
      end
    end
  end

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b1; clr = 1'b0; addr = '0; wdata = '0; wren = 1'b0; rden = 1'b0;
    sa = '0; sb1 = '0; rb = '0; sc = '0; c_undef = 1'b0;
    #1 rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    check("R2 reset A", q_a, '0);
    check("R2 reset B", q_b, '0);
    check("R2 reset C", q_c, '0);
    @(negedge clk);
    rst_n = 1'b1;

    // R11/R4: fill the array with read enable low; A and B hold zero
    for (int i = 0; i < DEPTH; i++) begin
      cyc(AW'(i), WIDTH'(32'hA5000000 + i * 32'h11), 1'b1, 1'b0, 1'b0, "R4 R11 fill");
    end
    // R3/R8: plain reads
    cyc(8'd3, '0, 1'b0, 1'b1, 1'b0, "R3 read 3");
    cyc(8'd9, '0, 1'b0, 1'b1, 1'b0, "R3 R9 read 9");
    // R4/R8: read enable low, no write; C still reads
    cyc(8'd20, '0, 1'b0, 1'b0, 1'b0, "R4 R8 hold");
    cyc(8'd21, '0, 1'b0, 1'b0, 1'b0, "R4 R8 hold2");
    // R4/R11: write with read enable low, then read it back
    cyc(8'd3, 32'hDEADBEEF, 1'b1, 1'b0, 1'b0, "R4 write hold");
    cyc(8'd3, '0, 1'b0, 1'b1, 1'b0, "R11 readback");
    // R5/R6/R7: read and write together
    cyc(8'd5, 32'h12345678, 1'b1, 1'b1, 1'b0, "R5 R6 R7 rdw");
    cyc(8'd5, '0, 1'b0, 1'b1, 1'b0, "R7 after rdw");
    cyc(8'd6, 32'h0BADF00D, 1'b1, 1'b1, 1'b0, "R5 R6 rdw2");
    // R10: clear beats read, memory intact
    cyc(8'd6, '0, 1'b0, 1'b1, 1'b1, "R10 clear");
    cyc(8'd6, '0, 1'b0, 1'b1, 1'b0, "R10 intact");
    cyc(8'd7, '0, 1'b0, 1'b0, 1'b0, "R9 drain");
    // R1: both ends of the address range
    cyc(8'd255, 32'hFFFF0001, 1'b1, 1'b0, 1'b0, "R1 top write");
    cyc(8'd0, 32'h0000FFFE, 1'b1, 1'b0, 1'b0, "R1 bottom write");
    cyc(8'd255, '0, 1'b0, 1'b1, 1'b0, "R1 top read");
    cyc(8'd0, '0, 1'b0, 1'b1, 1'b0, "R1 bottom read");
    // mixed traffic
    for (int i = 0; i < 400; i++) begin
      cyc(AW'($urandom_range(0, DEPTH - 1)), WIDTH'($urandom),
          1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
          1'($urandom_range(0, 15) == 0), "R3 R4 R5 R6 R9 R10 mix");
    end
    cyc(8'd1, '0, 1'b0, 1'b0, 1'b0, "R9 tail");
    @(negedge clk);
    @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule